// File: doc/BRIEF.md
# Debug Module Register Front End

This block holds the register file of a debug module as seen from a debug bus master. Each request carries a 7-bit address, a read/write flag and 32-bit write data. One cycle later the block returns read data and an error flag. Behind these registers the block tracks, per hart, a halt request, a resume flag and a resume acknowledge. From the hart selected in the control register it builds a live status word, and it drives hart reset and system reset requests.

Abstract commands are sequenced by a two-state machine. In IDLE a launch with a clean error code takes the transition IDLE→BUSY and emits a one-cycle go pulse. A launch is a command-register write, or an access to a data or program-buffer word whose auto-execute bit is set. In BUSY the done input takes the transition BUSY→IDLE. Clearing the active bit in the control register forces a transition from either state to IDLE. The command generator that consumes the go pulse sits outside this block, as does the hart-side memory window.

Top module: `dbg_regfront`

## Requirements
- R1: After reset the control register and the auto-execute register read 0. The abstract control/status register reads datacount 2 in bits [3:0], progbufsize in [28:24], error code 0 in [10:8] and busy 0 in bit 12. No go pulse and no halt request is active.
- R2: The status register always reads version 2 in [3:0], authenticated (bit 7) and implicit-ebreak (bit 22). For a selected hart that exists, bits 9/8 are set when the hart is halted and bits 11/10 when it is running. Bits 17/16 are set when its resume acknowledge is set. For a hart that does not exist, bits 15/14 are set.
- R3: While busy, a read of a data word (addresses 0x04..0x05) or a program-buffer word (0x20..) returns 0xFFFFFFFF.
- R4: While busy, writes to data or program-buffer words are dropped. A data access while busy sets error code 1 if the code is 0.
- R5: When not busy, an access to data word i with auto-execute-data bit i set (register 0x18, bits [1:0]) launches a command. The same holds for program-buffer word i with bit 16+i set.
- R6: Writing register 0x16 clears only the error-code bits written as 1. No other bit of that register changes. A nonzero error code stays until it is cleared this way.
- R7: A write to control (0x10) with bit 0 clear resets the control fields, the error code, busy, the auto-execute bits and every hart's halt request.
- R8: A control write with bit 0 set latches haltreq (31), resumereq (30), hartreset (29), hartsel [25:16] and system reset (1). The halt request of the selected hart follows haltreq. The hart reset output is asserted only for the selected hart.
- R9: A control write with resumereq raises the selected hart's resume flag and clears its acknowledge. A resumed pulse from that hart clears the flag and sets the acknowledge.
- R10: The command register (0x17) reads 0. A write stores the value and, when idle with error code 0, pulses go. A write while busy sets error code 1 if it is 0. A write while the error code is nonzero launches nothing.
- R11: Every request gets a response one cycle later. A request to an unmapped address gets the error flag.
- R12: The done input ends busy. The exception input sets error code 3 if the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped address |
| hart_halted_i | input | NHARTS | Per-hart halted level |
| hart_resumed_i | input | NHARTS | Per-hart resumed pulse |
| halt_req_o | output | NHARTS | Per-hart halt request |
| resume_req_o | output | NHARTS | Per-hart resume flag |
| hart_rst_o | output | NHARTS | Hart reset for the selected hart |
| ndmreset_o | output | 1 | System reset request |
| cmd_go_o | output | 1 | One-cycle command launch |
| cmd_o | output | 32 | Stored command word |
| cmd_done_i | input | 1 | Command finished |
| cmd_exc_i | input | 1 | Command raised an exception |

## Verification
The outputs below are due in the cycle after the clock edge that samples a request: the response, the go pulse, the new busy and error state, and the updated halt, resume and reset outputs. The same holds for a done, exception or resumed pulse. The bench drives every input at the falling edge and reads the outputs one time unit after the next rising edge. The register side effects are checked with a following read, which again samples one edge later. The status word is recomputed from the bench's own copy of the halted and acknowledge state.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam logic [6:0] A_DATA0 = 7'h04;
    localparam logic [6:0] A_CTRL  = 7'h10;
    localparam logic [6:0] A_STAT  = 7'h11;
    localparam logic [6:0] A_INFO  = 7'h12;
    localparam logic [6:0] A_ACS   = 7'h16;
    localparam logic [6:0] A_CMD   = 7'h17;
    localparam logic [6:0] A_AUTO  = 7'h18;
    localparam logic [6:0] A_PB0   = 7'h20;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUSY = 3'd1;
    localparam logic [2:0] ERR_NSUP = 3'd2;
    localparam logic [2:0] ERR_EXC  = 3'd3;
    localparam logic [2:0] ERR_HRES = 3'd4;

    typedef enum logic {ST_IDLE, ST_BUSY} abs_state_e;
endpackage

// File: rtl/dbg_abs_fsm.sv
module dbg_abs_fsm
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       launch,
    input  logic       busy_access,
    input  logic       done,
    input  logic       exc,
    input  logic       errclr_we,
    input  logic [2:0] errclr_mask,
    output logic       busy,
    output logic       go,
    output logic [2:0] cmderr
);
    abs_state_e st_q, st_d;
    logic       go_q, go_d;
    logic [2:0] err_q, err_d;

    always_comb begin
        st_d = st_q;
        go_d = 1'b0;
        unique case (st_q)
            ST_IDLE: if (launch && err_q == ERR_NONE) begin
                st_d = ST_BUSY;
                go_d = 1'b1;
            end
            ST_BUSY: if (done) st_d = ST_IDLE;
        endcase
        err_d = err_q;
        if (errclr_we) err_d = err_q & ~errclr_mask;
        if (err_q == ERR_NONE) begin
            if (st_q == ST_BUSY && (launch || busy_access)) err_d = ERR_BUSY;
            else if (exc) err_d = ERR_EXC;
        end
        if (clr) begin
            st_d  = ST_IDLE;
            go_d  = 1'b0;
            err_d = ERR_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            go_q  <= 1'b0;
            err_q <= ERR_NONE;
        end else begin
            st_q  <= st_d;
            go_q  <= go_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        busy   = (st_q == ST_BUSY);
        go     = go_q;
        cmderr = err_q;
    end

    // R12
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> go);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != ERR_NONE) && !errclr_we && !clr |=> err_q == $past(err_q));
    // R10
    launch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(err_q) == ERR_NONE);
endmodule

// File: rtl/dbg_hart_track.sv
module dbg_hart_track #(
    parameter int NHARTS = 4,
    parameter int SEL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ctl_we,
    input  logic [SEL_W-1:0]  sel,
    input  logic              haltreq,
    input  logic              resumereq,
    input  logic [NHARTS-1:0] resumed,
    output logic [NHARTS-1:0] halt_q,
    output logic [NHARTS-1:0] resume_q,
    output logic [NHARTS-1:0] ack_q
);
    for (genvar h = 0; h < NHARTS; h++) begin : g_hart
        logic hit;
        assign hit = ctl_we && (sel == SEL_W'(h));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                halt_q[h]   <= 1'b0;
                resume_q[h] <= 1'b0;
                ack_q[h]    <= 1'b0;
            end else begin
                if (clr) halt_q[h] <= 1'b0;
                else if (hit) halt_q[h] <= haltreq;
                if (hit && resumereq) begin
                    resume_q[h] <= 1'b1;
                    ack_q[h]    <= 1'b0;
                end else if (resumed[h]) begin
                    resume_q[h] <= 1'b0;
                    ack_q[h]    <= 1'b1;
                end
            end
        end

        // R9
        resume_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(resume_q[h] && ack_q[h]));
    end
endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront
    import dbg_pkg::*;
#(
    parameter int NHARTS    = 4,
    parameter int SEL_W     = 10,
    parameter int DATA_N    = 2,
    parameter int PB_N      = 2,
    parameter int DATA_ADDR = 'h380
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [6:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NHARTS-1:0] hart_halted_i,
    input  logic [NHARTS-1:0] hart_resumed_i,
    output logic [NHARTS-1:0] halt_req_o,
    output logic [NHARTS-1:0] resume_req_o,
    output logic [NHARTS-1:0] hart_rst_o,
    output logic              ndmreset_o,
    output logic              cmd_go_o,
    output logic [31:0]       cmd_o,
    input  logic              cmd_done_i,
    input  logic              cmd_exc_i
);
    localparam int HW  = (NHARTS > 1) ? $clog2(NHARTS) : 1;
    localparam int DIW = (DATA_N > 1) ? $clog2(DATA_N) : 1;
    localparam int PIW = (PB_N > 1) ? $clog2(PB_N) : 1;

    logic              busy;
    logic [2:0]        cmderr;
    logic              active_q, resreq_q, hrst_q, ndm_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_N-1:0] autod_q;
    logic [PB_N-1:0]   autop_q;
    logic [31:0]       data_q [DATA_N];
    logic [31:0]       pb_q [PB_N];
    logic [31:0]       cmd_q;
    logic [NHARTS-1:0] ack_vec;

    logic wr, is_data, is_pb, ctl_wr, ctl_on, dm_clr, launch, busy_acc;
    logic [DIW-1:0] didx;
    logic [PIW-1:0] pidx;
    logic exist;
    logic [HW-1:0] hidx;
    logic [31:0] rd_data;
    logic rd_err;

    assign wr       = req_valid && req_write;
    assign is_data  = (req_addr >= A_DATA0) && (req_addr < A_DATA0 + 7'(DATA_N));
    assign is_pb    = (req_addr >= A_PB0) && (req_addr < A_PB0 + 7'(PB_N));
    assign didx     = DIW'(req_addr - A_DATA0);
    assign pidx     = PIW'(req_addr - A_PB0);
    assign ctl_wr   = wr && (req_addr == A_CTRL);
    assign ctl_on   = ctl_wr && req_wdata[0];
    assign dm_clr   = ctl_wr && !req_wdata[0];
    assign busy_acc = req_valid && is_data && busy;
    assign launch   = (wr && req_addr == A_CMD) ||
                      (req_valid && !busy && ((is_data && autod_q[didx]) ||
                                              (is_pb && autop_q[pidx])));
    assign exist    = sel_q < SEL_W'(NHARTS);
    assign hidx     = HW'(sel_q);

    dbg_abs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(dm_clr), .launch(launch),
        .busy_access(busy_acc), .done(cmd_done_i), .exc(cmd_exc_i),
        .errclr_we(wr && req_addr == A_ACS), .errclr_mask(req_wdata[10:8]),
        .busy(busy), .go(cmd_go_o), .cmderr(cmderr)
    );

    dbg_hart_track #(.NHARTS(NHARTS), .SEL_W(SEL_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(dm_clr), .ctl_we(ctl_on),
        .sel(req_wdata[16 +: SEL_W]), .haltreq(req_wdata[31]),
        .resumereq(req_wdata[30]), .resumed(hart_resumed_i),
        .halt_q(halt_req_o), .resume_q(resume_req_o), .ack_q(ack_vec)
    );

    always_comb begin
        rd_data = '0;
        rd_err  = 1'b0;
        if (is_data) rd_data = busy ? '1 : data_q[didx];
        else if (is_pb) rd_data = busy ? '1 : pb_q[pidx];
        else begin
            case (req_addr)
                A_CTRL: begin
                    rd_data[31] = exist && halt_req_o[hidx];
                    rd_data[30] = resreq_q;
                    rd_data[29] = hrst_q;
                    rd_data[16 +: SEL_W] = sel_q;
                    rd_data[1]  = ndm_q;
                    rd_data[0]  = active_q;
                end
                A_STAT: begin
                    rd_data[3:0] = 4'd2;
                    rd_data[7]   = 1'b1;
                    rd_data[22]  = 1'b1;
                    if (exist) begin
                        if (hart_halted_i[hidx]) rd_data[9:8] = 2'b11;
                        else rd_data[11:10] = 2'b11;
                        if (ack_vec[hidx]) rd_data[17:16] = 2'b11;
                    end else begin
                        rd_data[15:14] = 2'b11;
                    end
                end
                A_INFO: rd_data = (32'd1 << 20) | (32'd1 << 16) |
                                  (32'(DATA_N) << 12) | 32'(DATA_ADDR & 'hfff);
                A_ACS:  rd_data = (32'(PB_N) << 24) | (32'(busy) << 12) |
                                  (32'(cmderr) << 8) | 32'(DATA_N);
                A_CMD:  rd_data = '0;
                A_AUTO: rd_data = 32'(autod_q) | (32'(autop_q) << 16);
                default: rd_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0; resreq_q <= 1'b0; hrst_q <= 1'b0; ndm_q <= 1'b0;
            sel_q <= '0; autod_q <= '0; autop_q <= '0; cmd_q <= '0;
            for (int i = 0; i < DATA_N; i++) data_q[i] <= '0;
            for (int i = 0; i < PB_N; i++) pb_q[i] <= '0;
            rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_err <= 1'b0;
        end else begin
            if (ctl_on) begin
                active_q <= 1'b1;
                resreq_q <= req_wdata[30];
                hrst_q   <= req_wdata[29];
                sel_q    <= req_wdata[16 +: SEL_W];
                ndm_q    <= req_wdata[1];
            end
            if (wr && req_addr == A_AUTO) begin
                autod_q <= req_wdata[DATA_N-1:0];
                autop_q <= req_wdata[16 +: PB_N];
            end
            if (dm_clr) begin
                active_q <= 1'b0; resreq_q <= 1'b0; hrst_q <= 1'b0;
                ndm_q <= 1'b0; sel_q <= '0; autod_q <= '0; autop_q <= '0;
            end
            if (wr && is_data && !busy) data_q[didx] <= req_wdata;
            if (wr && is_pb && !busy) pb_q[pidx] <= req_wdata;
            if (wr && req_addr == A_CMD) cmd_q <= req_wdata;
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_data : '0;
            rsp_err   <= req_valid && rd_err;
        end
    end

    for (genvar h = 0; h < NHARTS; h++) begin : g_rst
        assign hart_rst_o[h] = hrst_q && (sel_q == SEL_W'(h));
    end
    assign ndmreset_o = ndm_q;
    assign cmd_o      = cmd_q;

    // R3
    busy_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && (is_data || is_pb) && busy |=> rsp_rdata == '1);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    hart_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hart_rst_o));
    // R2
    status_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr == A_STAT |=> rsp_rdata[3:0] == 4'd2);
endmodule

// File: tb/dbg_regfront_tb.sv
module dbg_regfront_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;
    localparam int PBN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err, ndmreset_o, cmd_go_o;
    logic [31:0] rsp_rdata, cmd_o;
    logic [NH-1:0] hart_halted_i = '0, hart_resumed_i = '0;
    logic [NH-1:0] halt_req_o, resume_req_o, hart_rst_o;
    logic cmd_done_i = 1'b0, cmd_exc_i = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [31:0] got;
    logic got_err, got_go, got_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_regfront #(.NHARTS(NH), .PB_N(PBN)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .hart_halted_i(hart_halted_i),
        .hart_resumed_i(hart_resumed_i), .halt_req_o(halt_req_o),
        .resume_req_o(resume_req_o), .hart_rst_o(hart_rst_o),
        .ndmreset_o(ndmreset_o), .cmd_go_o(cmd_go_o), .cmd_o(cmd_o),
        .cmd_done_i(cmd_done_i), .cmd_exc_i(cmd_exc_i)
    );

    function automatic logic [31:0] exp_acs(input logic b, input logic [2:0] e);
        return (32'(PBN) << 24) | (32'(b) << 12) | (32'(e) << 8) | 32'd2;
    endfunction

    function automatic logic [31:0] exp_stat(input logic ex, input logic hl, input logic ak);
        logic [31:0] s = 32'h0040_0082;
        if (!ex) s |= 32'h0000_C000;
        else begin
            s |= hl ? 32'h0000_0300 : 32'h0000_0C00;
            if (ak) s |= 32'h0003_0000;
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic dmi(input logic we, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        got = rsp_rdata; got_err = rsp_err; got_go = cmd_go_o; got_vld = rsp_valid;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); cmd_done_i = 1'b1;
        @(negedge clk); cmd_done_i = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); cmd_exc_i = 1'b1;
        @(negedge clk); cmd_exc_i = 1'b0;
    endtask

    task automatic pulse_resumed(input int h);
        @(negedge clk); hart_resumed_i[h] = 1'b1;
        @(negedge clk); hart_resumed_i[h] = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] data_m [2];
        logic [31:0] pb_m [2];
        logic busy_m;
        logic [2:0] err_m;
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        data_m[0] = '0; data_m[1] = '0; pb_m[0] = '0; pb_m[1] = '0;
        busy_m = 1'b0; err_m = 3'd0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        dmi(1'b0, 7'h16, '0); chk("R1 acs", got, exp_acs(1'b0, 3'd0));
        dmi(1'b0, 7'h10, '0); chk("R1 ctrl", got, 32'h0);
        dmi(1'b0, 7'h18, '0); chk("R1 auto", got, 32'h0);
        chk("R1 halt", 32'(halt_req_o), 32'h0);
        chk("R11 valid", 32'(got_vld), 32'h1);

        // R2 status
        dmi(1'b1, 7'h10, 32'h1);
        dmi(1'b0, 7'h11, '0); chk("R2 running", got, exp_stat(1'b1, 1'b0, 1'b0));
        hart_halted_i = 4'b0001;
        dmi(1'b0, 7'h11, '0); chk("R2 halted", got, exp_stat(1'b1, 1'b1, 1'b0));
        dmi(1'b1, 7'h10, (32'd5 << 16) | 32'h1);
        dmi(1'b0, 7'h11, '0); chk("R2 nonexistent", got, exp_stat(1'b0, 1'b0, 1'b0));
        dmi(1'b0, 7'h10, '0); chk("R8 ctrl sel", got, (32'd5 << 16) | 32'h1);
        dmi(1'b1, 7'h10, 32'h1);

        // Constrained random: data, program buffer, commands, done, error clear
        for (int it = 0; it < 300; it++) begin
            int op;
            int i;
            logic [31:0] v;
            logic eg;
            op = int'($urandom % 8);
            i = int'($urandom % 2);
            v = $urandom;
            case (op)
                0, 1: begin
                    dmi(1'b1, 7'h04 + 7'(i), v);
                    if (busy_m) begin if (err_m == 3'd0) err_m = 3'd1; end
                    else data_m[i] = v;
                    chk("R4 data write no go", 32'(got_go), 32'h0);
                end
                2: begin
                    dmi(1'b0, 7'h04 + 7'(i), '0);
                    chk("R3 data read", got, busy_m ? 32'hFFFF_FFFF : data_m[i]);
                    if (busy_m && err_m == 3'd0) err_m = 3'd1;
                end
                3: begin
                    dmi(1'b1, 7'h20 + 7'(i), v);
                    if (!busy_m) pb_m[i] = v;
                end
                4: begin
                    dmi(1'b0, 7'h20 + 7'(i), '0);
                    chk("R3 progbuf read", got, busy_m ? 32'hFFFF_FFFF : pb_m[i]);
                end
                5: begin
                    dmi(1'b1, 7'h17, v);
                    eg = !busy_m && err_m == 3'd0;
                    if (busy_m && err_m == 3'd0) err_m = 3'd1;
                    if (eg) busy_m = 1'b1;
                    chk("R10 go", 32'(got_go), 32'(eg));
                end
                6: begin
                    pulse_done();
                    busy_m = 1'b0;
                end
                default: begin
                    dmi(1'b1, 7'h16, 32'h700);
                    err_m = 3'd0;
                    dmi(1'b0, 7'h16, '0);
                    chk("R6 acs random", got, exp_acs(busy_m, err_m));
                end
            endcase
        end
        pulse_done();
        dmi(1'b1, 7'h16, 32'h700);

        // R11 unmapped
        dmi(1'b0, 7'h30, '0); chk("R11 unmapped err", 32'(got_err), 32'h1);
        dmi(1'b0, 7'h12, '0); chk("R11 mapped ok", 32'(got_err), 32'h0);

        // R10 command launch
        dmi(1'b1, 7'h04, 32'hA5A5_0001);
        dmi(1'b1, 7'h21, 32'h1234_5678);
        dmi(1'b1, 7'h17, 32'h0022_1000);
        chk("R10 go", 32'(got_go), 32'h1);
        chk("R10 cmd stored", cmd_o, 32'h0022_1000);
        dmi(1'b0, 7'h17, '0); chk("R10 cmd reads 0", got, 32'h0);
        dmi(1'b0, 7'h16, '0); chk("R12 busy set", got, exp_acs(1'b1, 3'd0));

        // R3 / R4 lockout
        dmi(1'b0, 7'h04, '0); chk("R3 data ones", got, 32'hFFFF_FFFF);
        dmi(1'b0, 7'h21, '0); chk("R3 pb ones", got, 32'hFFFF_FFFF);
        dmi(1'b1, 7'h04, 32'hDEAD_BEEF);
        dmi(1'b1, 7'h21, 32'hDEAD_BEEF);
        dmi(1'b0, 7'h16, '0); chk("R4 err busy", got, exp_acs(1'b1, 3'd1));
        pulse_done();
        dmi(1'b0, 7'h04, '0); chk("R4 data kept", got, 32'hA5A5_0001);
        dmi(1'b0, 7'h21, '0); chk("R4 pb kept", got, 32'h1234_5678);
        dmi(1'b0, 7'h16, '0); chk("R12 done", got, exp_acs(1'b0, 3'd1));

        // R10 blocked by error, R6 clear rules
        dmi(1'b1, 7'h17, 32'h1);
        chk("R10 no go on err", 32'(got_go), 32'h0);
        dmi(1'b1, 7'h16, 32'h1F00_1003);
        dmi(1'b0, 7'h16, '0); chk("R6 no write", got, exp_acs(1'b0, 3'd1));
        dmi(1'b1, 7'h16, 32'h100);
        dmi(1'b0, 7'h16, '0); chk("R6 w1c", got, exp_acs(1'b0, 3'd0));

        // R10 command while busy
        dmi(1'b1, 7'h17, 32'h2);
        dmi(1'b1, 7'h17, 32'h3);
        chk("R10 busy no go", 32'(got_go), 32'h0);
        dmi(1'b0, 7'h16, '0); chk("R10 busy err", got, exp_acs(1'b1, 3'd1));
        pulse_done();
        dmi(1'b1, 7'h16, 32'h700);

        // R12 exception, R6 per-bit clear
        dmi(1'b1, 7'h17, 32'h4);
        pulse_exc();
        dmi(1'b0, 7'h16, '0); chk("R12 exc", got, exp_acs(1'b1, 3'd3));
        pulse_done();
        dmi(1'b1, 7'h16, 32'h100);
        dmi(1'b0, 7'h16, '0); chk("R6 partial", got, exp_acs(1'b0, 3'd2));
        dmi(1'b1, 7'h16, 32'h700);

        // R5 autoexec
        dmi(1'b1, 7'h18, 32'h0001_0002);
        dmi(1'b0, 7'h18, '0); chk("R5 auto reg", got, 32'h0001_0002);
        dmi(1'b0, 7'h05, '0); chk("R5 data1 go", 32'(got_go), 32'h1);
        pulse_done();
        dmi(1'b1, 7'h20, 32'h55); chk("R5 pb0 go", 32'(got_go), 32'h1);
        pulse_done();
        dmi(1'b0, 7'h04, '0); chk("R5 data0 no go", 32'(got_go), 32'h0);
        dmi(1'b1, 7'h18, 32'h0);

        // R9 resume
        dmi(1'b1, 7'h10, 32'h4000_0001);
        chk("R9 resume flag", 32'(resume_req_o), 32'h1);
        pulse_resumed(0);
        chk("R9 flag cleared", 32'(resume_req_o), 32'h0);
        dmi(1'b0, 7'h11, '0); chk("R9 ack", got, exp_stat(1'b1, 1'b1, 1'b1));
        dmi(1'b1, 7'h10, 32'h4000_0001);
        dmi(1'b0, 7'h11, '0); chk("R9 ack cleared", got, exp_stat(1'b1, 1'b1, 1'b0));
        pulse_resumed(0);

        // R8 halt and resets
        dmi(1'b1, 7'h10, 32'h8002_0001);
        chk("R8 halt hart2", 32'(halt_req_o), 32'h4);
        dmi(1'b0, 7'h10, '0); chk("R8 ctrl read", got, 32'h8002_0001);
        dmi(1'b1, 7'h10, 32'h8001_0001);
        chk("R8 halt hart1", 32'(halt_req_o), 32'h6);
        dmi(1'b1, 7'h10, 32'h2002_0001);
        chk("R8 hart reset", 32'(hart_rst_o), 32'h4);
        chk("R8 haltreq dropped", 32'(halt_req_o), 32'h2);
        dmi(1'b1, 7'h10, 32'h3);
        chk("R8 ndmreset", 32'(ndmreset_o), 32'h1);

        // R7 active clear
        dmi(1'b1, 7'h18, 32'h1);
        dmi(1'b1, 7'h17, 32'h9);
        dmi(1'b1, 7'h17, 32'h9);
        dmi(1'b1, 7'h10, 32'h0);
        chk("R7 halt cleared", 32'(halt_req_o), 32'h0);
        chk("R7 ndmreset cleared", 32'(ndmreset_o), 32'h0);
        dmi(1'b0, 7'h16, '0); chk("R7 acs", got, exp_acs(1'b0, 3'd0));
        dmi(1'b0, 7'h18, '0); chk("R7 auto", got, 32'h0);
        dmi(1'b0, 7'h10, '0); chk("R7 ctrl", got, 32'h0);

        finish_run();
    end
endmodule